// File: doc/BRIEF.md
# BIST Reconfiguration Sequencer

This block is the hardware control loop for a self-test session of a programmable array. It takes a small set of configuration values and walks the reconfiguration work for one session. Those values are a mask of the columns that hold blocks under test, a count of minor addresses for each test phase, and a limit on how long a test may run.

The walk has four nested levels, outermost first: test phase, configuration row within the active half of the array, column, and minor address. The sequencer raises one multi-frame write request for each minor address of each selected column. Each request carries its row, column and minor fields and goes to an external frame expander, which accepts it with an acknowledge. Columns whose mask bit is clear are skipped.

When a phase has no writes left, the sequencer pulses a test-execute strobe and waits for test completion. It then latches the pass/fail result for that phase and moves on. After the last phase it sets a done bit. If a test takes longer than the programmed limit, the sequencer stops the session and flags an error instead.

Top module: `bist_reconfig_seq`

## Requirements
- R1: After reset, `busy`, `wr_req`, `bist_run`, `ctrl_done` and `err_tmo` are 0 and `status_fail` is all zeros.
- R2: A `start` pulse seen while idle latches `cfg_col_mask`, `cfg_minor_cnt` and `cfg_tmo_limit`, clears `status_fail`, `ctrl_done` and `err_tmo`, and sets `busy`. A `start` seen while busy is ignored, and so is any change to the configuration inputs while busy.
- R3: Write requests follow this order. Phase runs from 0 upward as the outermost level. Within a phase, row runs from 0 to NUM_ROWS-1. Within a row, column runs in ascending order. Within a column, `wr_minor` runs from 0 to the phase count minus 1. The count for phase p is `cfg_minor_cnt[p*MINOR_W +: MINOR_W]`.
- R4: A column is written only if its bit `cfg_col_mask[c]` is 1. A phase whose minor count is 0, or a mask of all zeros, produces no write requests, but the phase still runs its test.
- R5: `wr_req` stays high with stable `wr_row`, `wr_col` and `wr_minor` until `wr_ack` is sampled high. Each clock cycle in which both `wr_req` and `wr_ack` are high completes exactly one write.
- R6: After the last write of a phase, `bist_run` is high for exactly one cycle. No write request is raised again until `bist_complete` has been seen.
- R7: When `bist_complete` is sampled, `bist_fail` is stored into `status_fail[phase]`, where 1 means the phase failed.
- R8: When the last phase (NUM_PHASES-1) completes, `ctrl_done` becomes 1 and `busy` becomes 0. `ctrl_done` stays 1 until the next accepted `start`.
- R9: `bist_complete` must arrive within a set window. Counting the first cycle after the `bist_run` pulse as 0, the sequencer waits through cycle `cfg_tmo_limit`. If `bist_complete` has not arrived by then, it sets `err_tmo`, clears `busy`, leaves `ctrl_done` at 0 and runs no further phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (accepted when idle) |
| cfg_col_mask | input | NUM_COLS | Block-under-test column mask, bit c = column c |
| cfg_minor_cnt | input | NUM_PHASES*MINOR_W | Minor-address count per phase, phase p at [p*MINOR_W +: MINOR_W] |
| cfg_tmo_limit | input | TMO_W | Test-complete wait limit in cycles |
| wr_req | output | 1 | Multi-frame write request to the frame expander |
| wr_ack | input | 1 | Write accepted |
| wr_row | output | ROW_W | Configuration row of the request |
| wr_col | output | COL_W | Column of the request |
| wr_minor | output | MINOR_W | Minor address of the request |
| bist_run | output | 1 | One-cycle test-execute strobe |
| bist_complete | input | 1 | Test of the current phase finished |
| bist_fail | input | 1 | Result of the test, valid with bist_complete |
| busy | output | 1 | Session in progress |
| ctrl_done | output | 1 | Done bit of the control register |
| err_tmo | output | 1 | Session aborted on test timeout |
| status_fail | output | NUM_PHASES | Per-phase fail bits |

## Verification
The bench computes the full expected request list for each session from the mask and the counts, and compares it against every request the expander receives, one entry at a time. Its acknowledge latency varies from request to request. A design that advanced before the acknowledge, scanned columns or minors in the wrong order, or wrote unmasked columns would show a mismatch or a wrong request total. The sessions it runs cover a phase with zero count, a mask with gaps, a mask of all zeros and a full count of seven minors, which targets off-by-one errors in the minor bound and the row and column wrap. At each test strobe the bench checks that every write of the phase has already finished, and it checks the fail bits against a known pattern. A stray `start` in mid-session and a test that never completes check that the latched configuration stays put and that the timeout aborts without setting done.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_COL   = 3'd1,
    S_WRITE = 3'd2,
    S_EXEC  = 3'd3,
    S_WAIT  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/bist_seq_cursor.sv
module bist_seq_cursor #(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 16,
  parameter int MINOR_W  = 6,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               step_col,
  input  logic               step_minor,
  input  logic [MINOR_W-1:0] minor_lim,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   col,
  output logic [MINOR_W-1:0] minor,
  output logic               last_col,
  output logic               last_row,
  output logic               last_minor
);

  assign last_col   = (col == COL_W'(NUM_COLS - 1));
  assign last_row   = (row == ROW_W'(NUM_ROWS - 1));
  assign last_minor = (minor == minor_lim - MINOR_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row   <= '0;
      col   <= '0;
      minor <= '0;
    end else if (step_col) begin
      minor <= '0;
      if (last_col) begin
        col <= '0;
        row <= last_row ? '0 : row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end else if (step_minor) begin
      minor <= minor + MINOR_W'(1);
    end
  end

  AST_MINOR_CLEARS_ON_COLUMN: assert property (@(posedge clk) disable iff (rst)
    step_col |=> (minor == '0)) else $error("minor not cleared on column step"); // R3

endmodule

// File: rtl/bist_seq_timer.sv
module bist_seq_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt_q;

  assign expired = en && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q != limit) begin
      cnt_q <= cnt_q + TMO_W'(1);
    end
  end

  AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0)) else $error("wait timer not restarted"); // R9

  AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= limit)) else $error("wait timer passed limit"); // R9

endmodule

// File: rtl/bist_seq_results.sv
module bist_seq_results #(
  parameter int NUM_PHASES = 6,
  localparam int PH_W      = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  capture,
  input  logic [PH_W-1:0]       idx,
  input  logic                  fail,
  output logic [NUM_PHASES-1:0] status
);

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        status[p] <= 1'b0;
      end else if (capture && (idx == PH_W'(p))) begin
        status[p] <= fail;
      end
    end
  end

  AST_ONE_BIT_PER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (capture && !clr) |=> ($countones(status ^ $past(status)) <= 1))
    else $error("capture touched more than one phase bit"); // R7

  AST_HOLD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clr) |=> $stable(status)) else $error("status changed without capture"); // R7

endmodule

// File: rtl/bist_reconfig_seq.sv
module bist_reconfig_seq
  import bist_seq_pkg::*;
#(
  parameter int NUM_PHASES = 6,
  parameter int NUM_ROWS   = 8,
  parameter int NUM_COLS   = 16,
  parameter int MINOR_W    = 6,
  parameter int TMO_W      = 20,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int PH_W      = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1,
  localparam int CNT_BITS  = NUM_PHASES * MINOR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_COLS-1:0]   cfg_col_mask,
  input  logic [CNT_BITS-1:0]   cfg_minor_cnt,
  input  logic [TMO_W-1:0]      cfg_tmo_limit,
  output logic                  wr_req,
  input  logic                  wr_ack,
  output logic [ROW_W-1:0]      wr_row,
  output logic [COL_W-1:0]      wr_col,
  output logic [MINOR_W-1:0]    wr_minor,
  output logic                  bist_run,
  input  logic                  bist_complete,
  input  logic                  bist_fail,
  output logic                  busy,
  output logic                  ctrl_done,
  output logic                  err_tmo,
  output logic [NUM_PHASES-1:0] status_fail
);

  seq_state_t            state_q, state_d;
  logic [NUM_COLS-1:0]   mask_q;
  logic [CNT_BITS-1:0]   cnt_q;
  logic [TMO_W-1:0]      lim_q;
  logic [PH_W-1:0]       phase_q;
  logic [MINOR_W-1:0]    cur_cnt;
  logic                  col_sel, last_col, last_row, last_minor, end_of_row_scan;
  logic                  accept, cur_clr, step_col, step_minor, wr_done;
  logic                  wait_en, expired, last_phase, complete_seen, timed_out;

  assign accept          = (state_q == S_IDLE) && start;
  assign cur_cnt         = cnt_q[phase_q*MINOR_W +: MINOR_W];
  assign col_sel         = mask_q[wr_col] && (cur_cnt != '0);
  assign end_of_row_scan = last_col && last_row;
  assign wr_done         = (state_q == S_WRITE) && wr_ack;
  assign wait_en         = (state_q == S_WAIT);
  assign complete_seen   = wait_en && bist_complete;
  assign timed_out       = wait_en && !bist_complete && expired;
  assign last_phase      = (phase_q == PH_W'(NUM_PHASES - 1));

  assign cur_clr    = accept || complete_seen;
  assign step_col   = ((state_q == S_COL) && !col_sel) || (wr_done && last_minor);
  assign step_minor = wr_done && !last_minor;

  assign wr_req   = (state_q == S_WRITE);
  assign bist_run = (state_q == S_EXEC);
  assign busy     = (state_q != S_IDLE);

  bist_seq_cursor #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .MINOR_W  (MINOR_W)
  ) u_cursor (
    .clk        (clk),
    .rst        (rst),
    .clr        (cur_clr),
    .step_col   (step_col),
    .step_minor (step_minor),
    .minor_lim  (cur_cnt),
    .row        (wr_row),
    .col        (wr_col),
    .minor      (wr_minor),
    .last_col   (last_col),
    .last_row   (last_row),
    .last_minor (last_minor)
  );

  bist_seq_timer #(
    .TMO_W (TMO_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (wait_en),
    .limit   (lim_q),
    .expired (expired)
  );

  bist_seq_results #(
    .NUM_PHASES (NUM_PHASES)
  ) u_results (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .capture (complete_seen),
    .idx     (phase_q),
    .fail    (bist_fail),
    .status  (status_fail)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_COL;
      S_COL: begin
        if (col_sel)              state_d = S_WRITE;
        else if (end_of_row_scan) state_d = S_EXEC;
      end
      S_WRITE: begin
        if (wr_ack && last_minor) state_d = end_of_row_scan ? S_EXEC : S_COL;
      end
      S_EXEC:  state_d = S_WAIT;
      S_WAIT: begin
        if (bist_complete)  state_d = last_phase ? S_IDLE : S_COL;
        else if (expired)   state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      mask_q    <= '0;
      cnt_q     <= '0;
      lim_q     <= '0;
      phase_q   <= '0;
      ctrl_done <= 1'b0;
      err_tmo   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mask_q    <= cfg_col_mask;
        cnt_q     <= cfg_minor_cnt;
        lim_q     <= cfg_tmo_limit;
        phase_q   <= '0;
        ctrl_done <= 1'b0;
        err_tmo   <= 1'b0;
      end
      if (complete_seen) begin
        if (last_phase) ctrl_done <= 1'b1;
        else            phase_q   <= phase_q + PH_W'(1);
      end
      if (timed_out) err_tmo <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!wr_req && !bist_run)) else $error("activity while idle"); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(mask_q) && $stable(cnt_q) && $stable(lim_q)))
    else $error("latched configuration changed mid-session"); // R2

  AST_MINOR_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_minor < cur_cnt)) else $error("minor beyond phase count"); // R3

  AST_COL_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> mask_q[wr_col]) else $error("unmasked column written"); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_row) && $stable(wr_col) && $stable(wr_minor)))
    else $error("request dropped or changed before acknowledge"); // R5

  AST_RUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    bist_run |=> !bist_run) else $error("execute strobe longer than one cycle"); // R6

  AST_RUN_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    bist_run |=> !wr_req) else $error("write right after execute strobe"); // R6

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_done && err_tmo)) else $error("done and timeout both set"); // R8

  AST_TMO_ENDS_SESSION: assert property (@(posedge clk) disable iff (rst)
    $rose(err_tmo) |-> !busy) else $error("session continued after timeout"); // R9

endmodule

// File: tb/bist_reconfig_seq_tb.sv
module bist_reconfig_seq_tb;

  localparam int NP = 3;
  localparam int NR = 2;
  localparam int NC = 4;
  localparam int MW = 3;
  localparam int TW = 8;
  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(NC);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [NC-1:0]  cfg_col_mask = '0;
  logic [NP*MW-1:0] cfg_minor_cnt = '0;
  logic [TW-1:0]  cfg_tmo_limit = '0;
  logic           wr_req, wr_ack = 1'b0;
  logic [RW-1:0]  wr_row;
  logic [CW-1:0]  wr_col;
  logic [MW-1:0]  wr_minor;
  logic           bist_run, bist_complete = 1'b0, bist_fail = 1'b0;
  logic           busy, ctrl_done, err_tmo;
  logic [NP-1:0]  status_fail;

  bist_reconfig_seq #(
    .NUM_PHASES (NP), .NUM_ROWS (NR), .NUM_COLS (NC), .MINOR_W (MW), .TMO_W (TW)
  ) u_dut (
    .clk (clk), .rst (rst), .start (start),
    .cfg_col_mask (cfg_col_mask), .cfg_minor_cnt (cfg_minor_cnt), .cfg_tmo_limit (cfg_tmo_limit),
    .wr_req (wr_req), .wr_ack (wr_ack), .wr_row (wr_row), .wr_col (wr_col), .wr_minor (wr_minor),
    .bist_run (bist_run), .bist_complete (bist_complete), .bist_fail (bist_fail),
    .busy (busy), .ctrl_done (ctrl_done), .err_tmo (err_tmo), .status_fail (status_fail)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int n_exp, wr_idx, run_idx, cyc;
  int exp_list [0:255];
  int ph_end [0:NP-1];
  logic [NP-1:0] fail_pat;
  bit   no_complete = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Expected request list: phase, row, ascending column, ascending minor.
  task automatic prepare(input logic [NC-1:0] m, input logic [NP*MW-1:0] c);
    n_exp = 0;
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++)
        for (int k = 0; k < NC; k++)
          if (m[k])
            for (int mi = 0; mi < int'(c[p*MW +: MW]); mi++) begin
              exp_list[n_exp] = (r << 16) | (k << 8) | mi;
              n_exp++;
            end
      ph_end[p] = n_exp;
    end
  endtask

  // Frame expander model with varying acknowledge latency.
  initial begin
    forever begin
      @(negedge clk);
      wr_ack = 1'b0;
      if (wr_req) begin
        int got;
        got = (int'(wr_row) << 16) | (int'(wr_col) << 8) | int'(wr_minor);
        if (wr_idx < n_exp)
          chk(got == exp_list[wr_idx], "R3/R4 request fields", got, exp_list[wr_idx]);
        else
          chk(1'b0, "R4 extra request", wr_idx, n_exp);
        repeat (wr_idx % 3) begin
          @(negedge clk);
          if (!wr_req) chk(1'b0, "R5 request dropped", 0, 1);
        end
        wr_idx++;
        wr_ack = 1'b1;
      end
    end
  end

  // Test engine model.
  initial begin
    forever begin
      @(negedge clk);
      bist_complete = 1'b0;
      if (bist_run) begin
        if (run_idx < NP)
          chk(wr_idx == ph_end[run_idx], "R6 all phase writes before run", wr_idx, ph_end[run_idx]);
        @(negedge clk);
        chk(!bist_run, "R6 run strobe one cycle", int'(bist_run), 0);
        if (!no_complete) begin
          repeat (run_idx % 3) @(negedge clk);
          bist_complete = 1'b1;
          bist_fail     = fail_pat[run_idx % NP];
        end
        run_idx++;
      end
    end
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic launch(input logic [NC-1:0] m, input logic [NP*MW-1:0] c,
                        input logic [TW-1:0] lim, input logic [NP-1:0] pat);
    prepare(m, c);
    wr_idx = 0;
    run_idx = 0;
    fail_pat = pat;
    @(negedge clk);
    cfg_col_mask = m;
    cfg_minor_cnt = c;
    cfg_tmo_limit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ctrl_done && !err_tmo && status_fail == '0, "R2 start accepted and clears", int'(busy), 1);
    cfg_col_mask = ~m;
    cfg_minor_cnt = '1;
  endtask

  task automatic finish_session(input logic [NP-1:0] pat);
    while (busy) @(negedge clk);
    chk(ctrl_done == 1'b1, "R8 done set", int'(ctrl_done), 1);
    chk(err_tmo == 1'b0, "R8 no error", int'(err_tmo), 0);
    chk(status_fail == pat, "R7 fail bits", int'(status_fail), int'(pat));
    chk(wr_idx == n_exp, "R3 request total", wr_idx, n_exp);
    chk(run_idx == NP, "R6 run count", run_idx, NP);
    repeat (4) @(negedge clk);
    chk(ctrl_done && !busy, "R8 done held", int'(ctrl_done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !wr_req && !bist_run && !ctrl_done && !err_tmo && status_fail == '0,
        "R1 reset state", int'(busy), 0);

    // Gapped mask, a zero-count phase.
    launch(4'b1011, {3'd3, 3'd0, 3'd2}, 8'd20, 3'b101);
    finish_session(3'b101);

    // Full mask, maximal count, stray start mid-session (R2 ignore).
    launch(4'b1111, {3'd4, 3'd7, 3'd1}, 8'd20, 3'b010);
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 stray start ignored", int'(busy), 1);
    finish_session(3'b010);

    // Timeout: no completion ever arrives.
    no_complete = 1'b1;
    launch(4'b0001, {3'd0, 3'd0, 3'd1}, 8'd3, 3'b000);
    while (run_idx == 0) @(negedge clk);
    chk(busy && !err_tmo, "R9 no early timeout", int'(err_tmo), 0);
    repeat (12) @(negedge clk);
    chk(err_tmo == 1'b1, "R9 timeout flagged", int'(err_tmo), 1);
    chk(!busy && !ctrl_done, "R9 aborted without done", int'(ctrl_done), 0);
    chk(run_idx == 1, "R9 no further phase", run_idx, 1);
    no_complete = 1'b0;
    @(negedge clk);

    // Empty mask: tests still run, no writes; error cleared by start.
    launch(4'b0000, {3'd3, 3'd3, 3'd3}, 8'd20, 3'b110);
    finish_session(3'b110);
    chk(wr_idx == 0, "R4 no writes with empty mask", wr_idx, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule